// File: doc/BRIEF.md
# Latched-Select Static RAM

This block is a 64-word by 8-bit read/write store that sits directly on a processor bus where the high and low address bytes share pins. One input pin, `sel_addr5`, does two jobs. While the address strobe `addr_stb` is high, the pin is sampled as a select term. When the strobe drops, the last sampled value is held and qualifies every later access. During the low-address phase the same pin acts as the sixth address bit. If the strobe is simply tied high, the block stays in plain mode. In plain mode the pin is only an address bit, and selection depends on the two chip-select inputs alone.

The data bus is carried as separate input, output and output-enable ports, so that the enclosing pad or bus logic can build the tri-state driver. The chain output `chain_out` is high whenever this block is selected, which holds a chained device deselected. It drops low to hand selection onward only when this block is not selected and a read is under way. Reads are combinational from the current address. Writes are committed on a clock edge. A write strobe overrides a read strobe, so one read/write line can drive both.

The select term comes from a three-state machine. `SEL_PLAIN` is the reset state. It moves to `SEL_HOLD` the first time the strobe is seen low. `SEL_HOLD` moves to `SEL_OPEN` when the strobe rises. `SEL_OPEN` returns to `SEL_HOLD` when the strobe falls. Only a reset leads back to `SEL_PLAIN`. While the strobe is high in `SEL_PLAIN` the select term is 1. While the strobe is high in any other state, the term follows the pin live. While the strobe is low, the term is the held bit, and that bit was loaded at every clock edge at which the strobe was high.

Top module: `latched_select_ram`

## Requirements
- R1: A write with the block selected and `wr_n` low stores `bus_in` at the clock edge, at word address {`sel_addr5`, `addr_low`}, where `sel_addr5` is bit 5. A later selected read of that address returns the value.
- R2: `bus_oe` is 1 only while the block is selected, `rd_n` is 0 and `wr_n` is 1. Whenever `bus_oe` is 0, `bus_out` is 0.
- R3: When `rd_n` and `wr_n` are both 0, the write takes place and `bus_oe` stays 0.
- R4: After reset, while `addr_stb` stays high, the block is selected whenever `cs_act_hi` is 1 and `cs_act_lo` is 0, for both values of `sel_addr5`. In that case `sel_addr5` only picks the upper or lower 32 words.
- R5: Once the strobe has gone low, the held select bit is the value of `sel_addr5` at the last clock edge at which `addr_stb` was high. It keeps that value until the strobe rises again. A held 0 blocks writes and reads, whatever value `sel_addr5` has later.
- R6: Outside plain mode, while `addr_stb` is high, the select term follows `sel_addr5` live, without waiting for a clock.
- R7: `chain_out` is 1 while selected. It is 0 only when the block is deselected and `rd_n` is 0. In every other case it is 1.
- R8: `cs_act_hi` = 0 or `cs_act_lo` = 1 deselects the block, whatever the state of the select term.
- R9: After reset `bus_oe` = 0, `bus_out` = 0 and `chain_out` = 1, with both strobes high.
- R10: During a selected read, `bus_out` follows a change of address with no clock edge in between.
- R11: A write attempt while the block is deselected leaves the stored word unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; writes and strobe sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_low | input | 5 | Word address bits 4..0 |
| sel_addr5 | input | 1 | Dual-use pin: select term while strobe high, address bit 5 otherwise |
| cs_act_hi | input | 1 | Chip select, active high |
| cs_act_lo | input | 1 | Chip select, active low |
| addr_stb | input | 1 | Address strobe; tie high for plain mode |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low; overrides `rd_n` |
| bus_in | input | 8 | Data from the shared bus |
| bus_out | output | 8 | Read data, zero when not driving |
| bus_oe | output | 1 | Drive enable for the tri-state bus buffer |
| chain_out | output | 1 | Chain enable for the next device's select input |

## Verification
A write and a read can be requested in the same cycle, and the bench provokes this by pulling `rd_n` and `wr_n` low together. It checks that `bus_oe` stays low during that cycle and that a later read returns the new word. The select-bit capture and an access can also overlap: with the strobe high outside plain mode, the bench toggles `sel_addr5` and expects `bus_oe` to follow at once. After the strobe falls, it checks that only the value from the last strobe-high edge still gates reads, writes and `chain_out`.

// File: rtl/lsr_pkg.sv
package lsr_pkg;
    typedef enum logic [1:0] {
        SEL_PLAIN = 2'd0,
        SEL_OPEN  = 2'd1,
        SEL_HOLD  = 2'd2
    } sel_state_e;
endpackage

// File: rtl/lsr_sel_tracker.sv
module lsr_sel_tracker
    import lsr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic sel_pin,
    output logic sel_term
);
    sel_state_e state_q, state_d;
    logic       held_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEL_PLAIN;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SEL_PLAIN: if (!strobe) state_d = SEL_HOLD;
            SEL_OPEN:  if (!strobe) state_d = SEL_HOLD;
            SEL_HOLD:  if (strobe)  state_d = SEL_OPEN;
            default:   state_d = SEL_PLAIN;
        endcase
    end

    // held select bit: loaded while the strobe is high
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      held_q <= 1'b0;
        else if (strobe) held_q <= sel_pin;
    end

    // output process
    always_comb begin
        sel_term = held_q;
        unique case (state_q)
            SEL_PLAIN: sel_term = strobe ? 1'b1 : held_q;
            SEL_OPEN,
            SEL_HOLD:  sel_term = strobe ? sel_pin : held_q;
            default:   sel_term = 1'b0;
        endcase
    end

    // R5
    property hold_stable_p;
        @(posedge clk) disable iff (!rst_n) !strobe |=> (held_q == $past(held_q));
    endproperty
    hold_stable_chk: assert property (hold_stable_p);

    // R5
    property capture_p;
        @(posedge clk) disable iff (!rst_n) strobe |=> (held_q == $past(sel_pin));
    endproperty
    capture_chk: assert property (capture_p);

    // R4
    property plain_exit_p;
        @(posedge clk) disable iff (!rst_n) (state_q != SEL_PLAIN) |=> (state_q != SEL_PLAIN);
    endproperty
    plain_exit_chk: assert property (plain_exit_p);
endmodule

// File: rtl/lsr_store.sv
module lsr_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[addr] <= wdata;
    end

    assign rdata = cells[addr];
endmodule

// File: rtl/lsr_bus_ctrl.sv
module lsr_bus_ctrl #(
    parameter int DATA_W = 8
) (
    input  logic              sel_term,
    input  logic              cs_act_hi,
    input  logic              cs_act_lo,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic              oe,
    output logic              chain,
    output logic [DATA_W-1:0] dout
);
    logic selected;

    always_comb begin
        selected = sel_term & cs_act_hi & ~cs_act_lo;
        we       = selected & ~wr_n;
        oe       = selected & ~rd_n & wr_n;
        chain    = selected | rd_n;
        dout     = oe ? rdata : '0;
    end
endmodule

// File: rtl/latched_select_ram.sv
module latched_select_ram #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-2:0] addr_low,
    input  logic              sel_addr5,
    input  logic              cs_act_hi,
    input  logic              cs_act_lo,
    input  logic              addr_stb,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic [DATA_W-1:0] bus_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              chain_out
);
    localparam int LO_W = ADDR_W - 1;

    logic              sel_term;
    logic              we;
    logic [DATA_W-1:0] rdata;
    logic [ADDR_W-1:0] word_addr;

    assign word_addr = {sel_addr5, addr_low[LO_W-1:0]};

    lsr_sel_tracker u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (addr_stb),
        .sel_pin  (sel_addr5),
        .sel_term (sel_term)
    );

    lsr_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .we    (we),
        .addr  (word_addr),
        .wdata (bus_in),
        .rdata (rdata)
    );

    lsr_bus_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .sel_term  (sel_term),
        .cs_act_hi (cs_act_hi),
        .cs_act_lo (cs_act_lo),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .rdata     (rdata),
        .we        (we),
        .oe        (bus_oe),
        .chain     (chain_out),
        .dout      (bus_out)
    );

    // R3
    property write_wins_p;
        @(posedge clk) disable iff (!rst_n) !wr_n |-> !bus_oe;
    endproperty
    write_wins_chk: assert property (write_wins_p);

    // R7
    property chain_on_drive_p;
        @(posedge clk) disable iff (!rst_n) bus_oe |-> chain_out;
    endproperty
    chain_on_drive_chk: assert property (chain_on_drive_p);

    // R8
    property cs_gate_p;
        @(posedge clk) disable iff (!rst_n) (!cs_act_hi || cs_act_lo) |-> (!bus_oe && (chain_out == rd_n));
    endproperty
    cs_gate_chk: assert property (cs_gate_p);

    // R2
    property quiet_bus_p;
        @(posedge clk) disable iff (!rst_n) !bus_oe |-> (bus_out == '0);
    endproperty
    quiet_bus_chk: assert property (quiet_bus_p);
endmodule

// File: tb/tb_latched_select_ram.sv
module tb_latched_select_ram;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] addr_low = '0;
    logic       sel_addr5 = 1'b0;
    logic       cs_act_hi = 1'b1;
    logic       cs_act_lo = 1'b0;
    logic       addr_stb = 1'b1;
    logic       rd_n = 1'b1;
    logic       wr_n = 1'b1;
    logic [7:0] bus_in = '0;
    logic [7:0] bus_out;
    logic       bus_oe;
    logic       chain_out;

    logic [7:0] ref_mem [64];
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    latched_select_ram dut (
        .clk(clk), .rst_n(rst_n), .addr_low(addr_low), .sel_addr5(sel_addr5),
        .cs_act_hi(cs_act_hi), .cs_act_lo(cs_act_lo), .addr_stb(addr_stb),
        .rd_n(rd_n), .wr_n(wr_n), .bus_in(bus_in), .bus_out(bus_out),
        .bus_oe(bus_oe), .chain_out(chain_out)
    );

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 50000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run hung, actual %0d cycles expected below 50000", cycles);
            finish_up();
        end
    end

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d, bit stores, string tag);
        @(negedge clk);
        addr_low = a[4:0]; sel_addr5 = a[5]; bus_in = d; wr_n = 1'b0;
        #2 chk({tag, " no drive during write"}, {7'd0, bus_oe}, 8'd0);
        @(posedge clk);
        #1 if (stores) ref_mem[a] = d;
        @(negedge clk);
        wr_n = 1'b1;
    endtask

    task automatic rd(logic [5:0] a, bit sel, string tag);
        @(negedge clk);
        addr_low = a[4:0]; sel_addr5 = a[5]; rd_n = 1'b0;
        #2;
        chk({tag, " oe"}, {7'd0, bus_oe}, {7'd0, sel});
        chk({tag, " chain R7"}, {7'd0, chain_out}, {7'd0, sel});
        chk({tag, " data"}, bus_out, sel ? ref_mem[a] : 8'd0);
        rd_n = 1'b1;
    endtask

    task automatic latch_select(bit v);
        @(negedge clk);
        sel_addr5 = v; addr_stb = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset;
        #35 rst_n = 1'b1;
        #2;
        chk("R9 oe", {7'd0, bus_oe}, 8'd0);
        chk("R9 data", bus_out, 8'd0);
        chk("R9 chain", {7'd0, chain_out}, 8'd1);
    endtask

    task automatic t_plain;
        for (int i = 0; i < 64; i++) wr(i[5:0], 8'((i * 37) + 5), 1'b1, "R1 fill");
        rd(6'd0, 1'b1, "R1 addr0");
        rd(6'd63, 1'b1, "R1 addr63");
        rd(6'd5, 1'b1, "R4 lower half");
        rd(6'd37, 1'b1, "R4 upper half");
    endtask

    task automatic t_follow;
        @(negedge clk);
        addr_low = 5'd9; sel_addr5 = 1'b0; rd_n = 1'b0;
        #1 chk("R10 first addr", bus_out, ref_mem[9]);
        addr_low = 5'd20; sel_addr5 = 1'b1;
        #1 chk("R10 changed addr", bus_out, ref_mem[52]);
        rd_n = 1'b1;
    endtask

    task automatic t_priority;
        @(negedge clk);
        addr_low = 5'd12; sel_addr5 = 1'b0; bus_in = 8'h5A; rd_n = 1'b0; wr_n = 1'b0;
        #2 chk("R3 oe low on both strobes", {7'd0, bus_oe}, 8'd0);
        @(posedge clk);
        #1 ref_mem[12] = 8'h5A;
        @(negedge clk);
        rd_n = 1'b1; wr_n = 1'b1;
        rd(6'd12, 1'b1, "R3 write took effect");
    endtask

    task automatic t_chipsel;
        cs_act_hi = 1'b0;
        wr(6'd10, 8'hAA, 1'b0, "R11 cs_hi low");
        rd(6'd10, 1'b0, "R8 cs_hi low");
        cs_act_hi = 1'b1; cs_act_lo = 1'b1;
        wr(6'd40, 8'hBB, 1'b0, "R11 cs_lo high");
        rd(6'd40, 1'b0, "R8 cs_lo high");
        #2 chk("R7 deselected idle chain", {7'd0, chain_out}, 8'd1);
        cs_act_lo = 1'b0;
        rd(6'd10, 1'b1, "R11 word 10 kept");
        rd(6'd40, 1'b1, "R11 word 40 kept");
    endtask

    task automatic t_latched;
        latch_select(1'b1);
        wr(6'd3, 8'h31, 1'b1, "R5 held1 low");
        wr(6'd35, 8'h35, 1'b1, "R5 held1 high");
        rd(6'd3, 1'b1, "R5 held1 read low");
        rd(6'd35, 1'b1, "R5 held1 read high");
        latch_select(1'b0);
        wr(6'd3, 8'hEE, 1'b0, "R5 held0");
        rd(6'd35, 1'b0, "R5 held0 pin high");
        rd(6'd3, 1'b0, "R5 held0 pin low");
    endtask

    task automatic t_transparent;
        @(negedge clk);
        addr_stb = 1'b1; sel_addr5 = 1'b1; addr_low = 5'd3; rd_n = 1'b0;
        #2 chk("R6 pin high oe", {7'd0, bus_oe}, 8'd1);
        chk("R6 pin high data", bus_out, ref_mem[35]);
        sel_addr5 = 1'b0;
        #1 chk("R6 pin low oe", {7'd0, bus_oe}, 8'd0);
        rd_n = 1'b1;
        @(negedge clk);
        addr_stb = 1'b0;
        @(negedge clk);
        rd(6'd35, 1'b0, "R5 last high edge captured 0");
        latch_select(1'b1);
        rd(6'd3, 1'b1, "R11 word 3 kept after held0 write");
    endtask

    task automatic t_sweep;
        for (int i = 0; i < 64; i++) rd(i[5:0], 1'b1, "R1 sweep");
    endtask

    initial begin
        t_reset();
        t_plain();
        t_follow();
        t_priority();
        t_chipsel();
        t_latched();
        t_transparent();
        t_sweep();
        finish_up();
    end
endmodule